// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative translation buffer that maps virtual page numbers to physical page numbers. Each slot carries a page tag, a physical page number, an address-space identifier, a global flag, per-privilege-mode read and write enable masks, and two trap flags (trap-on-read and trap-on-write). A lookup presents a page number together with the current address-space identifier. One cycle later the block reports hit or miss and the matched slot's fields. Trap handling, permission evaluation and table walking stay with the consumer of these fields.

In front of the main array sits a three-slot recent-hit cache. It remembers the indices of the last array hits. A lookup consults it before the array priority search, and the block reports which path produced the hit. Refills go through an insert port that always writes the slot named by a round-robin victim pointer. The pointer and the slot under it are visible on an index port, which can also step the pointer without writing. Three flush commands remove entries: all entries, all non-global entries, or the entries for one page in one address space. Any insert or flush empties the recent-hit cache.

Top module: `asn_tlb`

## Requirements
- R1: A slot matches a lookup when it is valid, its tag equals `lkp_vpn_i`, and either its global flag is 1 or its stored identifier equals `lkp_asn_i`. On a hit the outputs carry that slot's ppn, identifier, global flag, read mask, write mask and both trap flags. On a miss all of these outputs are 0.
- R2: The result of a lookup appears on the outputs in the cycle after `lkp_req_i` is high. In a cycle after one with `lkp_req_i` low, `lkp_hit_o` and `lkp_near_o` are 0.
- R3: When several array slots match and none is in the recent-hit cache, the lowest-index slot is reported.
- R4: The recent-hit cache is checked first, in slot order 0, 1, 2. A hit there is reported with `lkp_near_o`=1 even if a lower-index array slot also matches. An array hit reports `lkp_near_o`=0 and pushes its index into cache slot 0; the older cache slots shift down by one and the oldest is dropped.
- R5: An insert writes the slot at the victim pointer, overwriting any valid entry there. It marks the slot valid, stores `ins_vpn_i` as the tag, and advances the pointer. The pointer wraps from N_ENTRIES-1 to 0.
- R6: `vic_ptr_o` shows the victim pointer, and `vic_vld_o`, `vic_vpn_o` and `vic_ppn_o` show the slot it names. `vic_adv_i` steps the pointer without writing. An insert together with `vic_adv_i` steps it only once.
- R7: Any insert or any flush empties the recent-hit cache, so the next lookup reports `lkp_near_o`=0.
- R8: Flush-all invalidates every slot and sets the victim pointer to 0.
- R9: Flush-non-global invalidates every slot whose global flag is 0 and keeps the global slots.
- R10: Flush-page invalidates every valid slot whose tag equals `flush_vpn_i` and that is either global or holds `flush_asn_i`. All other slots are kept.
- R11: An insert in the same cycle as any flush is dropped: no slot is written and the pointer does not advance for it.
- R12: After reset all slots are invalid, the pointer is 0, the recent-hit cache is empty and `lkp_hit_o` is 0.
- R13: A lookup in the same cycle as an insert or flush sees the slot contents from before that cycle's update, and it does not fill the recent-hit cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lkp_req_i | input | 1 | Lookup request |
| lkp_vpn_i | input | VPN_W | Lookup virtual page number |
| lkp_asn_i | input | ASN_W | Current address-space identifier |
| lkp_hit_o | output | 1 | Lookup hit (one cycle after request) |
| lkp_near_o | output | 1 | Hit was found in the recent-hit cache |
| lkp_ppn_o | output | PPN_W | Physical page number of the hit |
| lkp_asn_o | output | ASN_W | Identifier stored in the hit slot |
| lkp_glb_o | output | 1 | Global flag of the hit slot |
| lkp_rd_en_o | output | MODE_W | Per-mode read enable mask |
| lkp_wr_en_o | output | MODE_W | Per-mode write enable mask |
| lkp_frd_o | output | 1 | Trap-on-read flag |
| lkp_fwr_o | output | 1 | Trap-on-write flag |
| ins_i | input | 1 | Insert at victim pointer |
| ins_vpn_i | input | VPN_W | Tag to insert |
| ins_ppn_i | input | PPN_W | Physical page number to insert |
| ins_asn_i | input | ASN_W | Identifier to insert |
| ins_glb_i | input | 1 | Global flag to insert |
| ins_rd_en_i | input | MODE_W | Read mask to insert |
| ins_wr_en_i | input | MODE_W | Write mask to insert |
| ins_frd_i | input | 1 | Trap-on-read to insert |
| ins_fwr_i | input | 1 | Trap-on-write to insert |
| flush_all_i | input | 1 | Invalidate all slots, pointer to 0 |
| flush_proc_i | input | 1 | Invalidate non-global slots |
| flush_addr_i | input | 1 | Invalidate slots of one page and identifier |
| flush_vpn_i | input | VPN_W | Page for flush-page |
| flush_asn_i | input | ASN_W | Identifier for flush-page |
| vic_adv_i | input | 1 | Step victim pointer |
| vic_ptr_o | output | IDX_W | Victim pointer |
| vic_vld_o | output | 1 | Valid flag of slot at pointer |
| vic_vpn_o | output | VPN_W | Tag of slot at pointer |
| vic_ppn_o | output | PPN_W | Ppn of slot at pointer |

## Verification
The assertions treat each request and command input as a known 0 or 1 on every clock edge after reset. The pointer-step property also relies on the block being built with N_ENTRIES of at least 2. No assumption is made about which commands arrive together: insert, flush and step may coincide, and the properties state the priority outcome for each combination. The stimulus drives every input on the falling edge from a fully known idle value and returns it to idle after each operation. It issues insert-with-flush and insert-with-step deliberately, so that the combined cases are exercised within those input rules.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned NEAR_SLOTS = 3;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_NEAR  = 2'd1,
    SRC_ARRAY = 2'd2
  } hit_src_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N_ENTRIES = 64,
  parameter int unsigned VPN_W     = 28,
  parameter int unsigned ASN_W     = 8
) (
  input  logic [N_ENTRIES-1:0]            vld_i,
  input  logic [N_ENTRIES-1:0]            glb_i,
  input  logic [N_ENTRIES-1:0][VPN_W-1:0] tag_i,
  input  logic [N_ENTRIES-1:0][ASN_W-1:0] asn_i,
  input  logic [VPN_W-1:0]                vpn_i,
  input  logic [ASN_W-1:0]                req_asn_i,
  output logic [N_ENTRIES-1:0]            hit_o
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign hit_o[g] = vld_i[g] && (tag_i[g] == vpn_i) &&
                      (glb_i[g] || (asn_i[g] == req_asn_i));
  end
endmodule

// File: rtl/tlb_first.sv
module tlb_first #(
  parameter int unsigned N_ENTRIES = 64,
  parameter int unsigned IDX_W     = 6
) (
  input  logic [N_ENTRIES-1:0] req_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  // downward scan: lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/tlb_recent.sv
module tlb_recent
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 64,
  parameter int unsigned IDX_W     = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic [N_ENTRIES-1:0] match_i,
  input  logic                 promote_i,
  input  logic [IDX_W-1:0]     promote_idx_i,
  output logic                 near_o,
  output logic [IDX_W-1:0]     near_idx_o
);
  logic [NEAR_SLOTS-1:0]            slot_v_q;
  logic [NEAR_SLOTS-1:0][IDX_W-1:0] slot_idx_q;

  // slot 0 has priority: scan downward so lowest slot wins
  always_comb begin
    near_o     = 1'b0;
    near_idx_o = '0;
    for (int k = NEAR_SLOTS - 1; k >= 0; k--) begin
      if (slot_v_q[k] && match_i[slot_idx_q[k]]) begin
        near_o     = 1'b1;
        near_idx_o = slot_idx_q[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_v_q   <= '0;
      slot_idx_q <= '0;
    end else if (clear_i) begin
      slot_v_q <= '0;
    end else if (promote_i) begin
      for (int k = NEAR_SLOTS - 1; k > 0; k--) begin
        slot_v_q[k]   <= slot_v_q[k-1];
        slot_idx_q[k] <= slot_idx_q[k-1];
      end
      slot_v_q[0]   <= 1'b1;
      slot_idx_q[0] <= promote_idx_i;
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N_ENTRIES = 64,
  parameter int unsigned IDX_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (restart_i) ptr_q <= '0;
    else if (step_i)    ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 64,
  parameter int unsigned VPN_W     = 28,
  parameter int unsigned PPN_W     = 28,
  parameter int unsigned ASN_W     = 8,
  parameter int unsigned MODE_W    = 4,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_req_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  input  logic [ASN_W-1:0]  lkp_asn_i,
  output logic              lkp_hit_o,
  output logic              lkp_near_o,
  output logic [PPN_W-1:0]  lkp_ppn_o,
  output logic [ASN_W-1:0]  lkp_asn_o,
  output logic              lkp_glb_o,
  output logic [MODE_W-1:0] lkp_rd_en_o,
  output logic [MODE_W-1:0] lkp_wr_en_o,
  output logic              lkp_frd_o,
  output logic              lkp_fwr_o,
  input  logic              ins_i,
  input  logic [VPN_W-1:0]  ins_vpn_i,
  input  logic [PPN_W-1:0]  ins_ppn_i,
  input  logic [ASN_W-1:0]  ins_asn_i,
  input  logic              ins_glb_i,
  input  logic [MODE_W-1:0] ins_rd_en_i,
  input  logic [MODE_W-1:0] ins_wr_en_i,
  input  logic              ins_frd_i,
  input  logic              ins_fwr_i,
  input  logic              flush_all_i,
  input  logic              flush_proc_i,
  input  logic              flush_addr_i,
  input  logic [VPN_W-1:0]  flush_vpn_i,
  input  logic [ASN_W-1:0]  flush_asn_i,
  input  logic              vic_adv_i,
  output logic [IDX_W-1:0]  vic_ptr_o,
  output logic              vic_vld_o,
  output logic [VPN_W-1:0]  vic_vpn_o,
  output logic [PPN_W-1:0]  vic_ppn_o
);
  // entry storage
  logic [N_ENTRIES-1:0]             vld_q, vld_d;
  logic [N_ENTRIES-1:0]             glb_q, frd_q, fwr_q;
  logic [N_ENTRIES-1:0][VPN_W-1:0]  tag_q;
  logic [N_ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [N_ENTRIES-1:0][ASN_W-1:0]  asn_q;
  logic [N_ENTRIES-1:0][MODE_W-1:0] rd_q, wr_q;

  logic             flush_any, ins_go, cache_clr;
  logic [IDX_W-1:0] ptr;
  logic [N_ENTRIES-1:0] lkp_match, fl_match, inv;

  assign flush_any = flush_all_i | flush_proc_i | flush_addr_i;
  assign ins_go    = ins_i & ~flush_any;
  assign cache_clr = ins_go | flush_any;

  tlb_victim #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (flush_all_i),
    .step_i    (ins_go | vic_adv_i),
    .ptr_o     (ptr)
  );

  tlb_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lkp_match (
    .vld_i     (vld_q),
    .glb_i     (glb_q),
    .tag_i     (tag_q),
    .asn_i     (asn_q),
    .vpn_i     (lkp_vpn_i),
    .req_asn_i (lkp_asn_i),
    .hit_o     (lkp_match)
  );

  tlb_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
    .vld_i     (vld_q),
    .glb_i     (glb_q),
    .tag_i     (tag_q),
    .asn_i     (asn_q),
    .vpn_i     (flush_vpn_i),
    .req_asn_i (flush_asn_i),
    .hit_o     (fl_match)
  );

  // invalidation vector
  always_comb begin
    if (flush_all_i) inv = '1;
    else inv = ({N_ENTRIES{flush_proc_i}} & ~glb_q) |
               ({N_ENTRIES{flush_addr_i}} & fl_match);
  end

  always_comb begin
    vld_d = vld_q & ~inv;
    if (ins_go) vld_d[ptr] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= vld_d;
  end

  always_ff @(posedge clk_i) begin
    if (ins_go) begin
      tag_q[ptr] <= ins_vpn_i;
      ppn_q[ptr] <= ins_ppn_i;
      asn_q[ptr] <= ins_asn_i;
      glb_q[ptr] <= ins_glb_i;
      rd_q[ptr]  <= ins_rd_en_i;
      wr_q[ptr]  <= ins_wr_en_i;
      frd_q[ptr] <= ins_frd_i;
      fwr_q[ptr] <= ins_fwr_i;
    end
  end

  // lookup path
  logic             arr_any, near_hit;
  logic [IDX_W-1:0] arr_idx, near_idx, sel_idx;
  hit_src_e         src;

  tlb_first #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_first (
    .req_i (lkp_match),
    .any_o (arr_any),
    .idx_o (arr_idx)
  );

  tlb_recent #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_recent (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (cache_clr),
    .match_i       (lkp_match),
    .promote_i     (src == SRC_ARRAY),
    .promote_idx_i (arr_idx),
    .near_o        (near_hit),
    .near_idx_o    (near_idx)
  );

  always_comb begin
    if (!lkp_req_i)    src = SRC_NONE;
    else if (near_hit) src = SRC_NEAR;
    else if (arr_any)  src = SRC_ARRAY;
    else               src = SRC_NONE;
  end

  assign sel_idx = (src == SRC_NEAR) ? near_idx : arr_idx;

  logic hit_q, near_q, glb_o_q, frd_o_q, fwr_o_q;
  logic [PPN_W-1:0]  ppn_o_q;
  logic [ASN_W-1:0]  asn_o_q;
  logic [MODE_W-1:0] rd_o_q, wr_o_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      near_q  <= 1'b0;
      ppn_o_q <= '0;
      asn_o_q <= '0;
      glb_o_q <= 1'b0;
      rd_o_q  <= '0;
      wr_o_q  <= '0;
      frd_o_q <= 1'b0;
      fwr_o_q <= 1'b0;
    end else if (src != SRC_NONE) begin
      hit_q   <= 1'b1;
      near_q  <= (src == SRC_NEAR);
      ppn_o_q <= ppn_q[sel_idx];
      asn_o_q <= asn_q[sel_idx];
      glb_o_q <= glb_q[sel_idx];
      rd_o_q  <= rd_q[sel_idx];
      wr_o_q  <= wr_q[sel_idx];
      frd_o_q <= frd_q[sel_idx];
      fwr_o_q <= fwr_q[sel_idx];
    end else begin
      hit_q   <= 1'b0;
      near_q  <= 1'b0;
      ppn_o_q <= '0;
      asn_o_q <= '0;
      glb_o_q <= 1'b0;
      rd_o_q  <= '0;
      wr_o_q  <= '0;
      frd_o_q <= 1'b0;
      fwr_o_q <= 1'b0;
    end
  end

  assign lkp_hit_o   = hit_q;
  assign lkp_near_o  = near_q;
  assign lkp_ppn_o   = ppn_o_q;
  assign lkp_asn_o   = asn_o_q;
  assign lkp_glb_o   = glb_o_q;
  assign lkp_rd_en_o = rd_o_q;
  assign lkp_wr_en_o = wr_o_q;
  assign lkp_frd_o   = frd_o_q;
  assign lkp_fwr_o   = fwr_o_q;

  assign vic_ptr_o = ptr;
  assign vic_vld_o = vld_q[ptr];
  assign vic_vpn_o = tag_q[ptr];
  assign vic_ppn_o = ppn_q[ptr];
endmodule

// File: rtl/asn_tlb_chk.sv
module asn_tlb_chk #(
  parameter int unsigned N_ENTRIES = 64,
  parameter int unsigned PPN_W     = 28,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lkp_req_i,
  input logic             lkp_hit_o,
  input logic             lkp_near_o,
  input logic [PPN_W-1:0] lkp_ppn_o,
  input logic             ins_i,
  input logic             flush_all_i,
  input logic             flush_proc_i,
  input logic             flush_addr_i,
  input logic             vic_adv_i,
  input logic [IDX_W-1:0] vic_ptr_o,
  input logic             vic_vld_o
);
  logic             fl_any;
  logic [IDX_W-1:0] ptr_nxt;

  assign fl_any  = flush_all_i | flush_proc_i | flush_addr_i;
  assign ptr_nxt = (vic_ptr_o == IDX_W'(N_ENTRIES - 1)) ? '0 : vic_ptr_o + 1'b1;

  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_hit_o |-> (lkp_ppn_o == '0)); // R1

  AST_IDLE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_req_i |=> (!lkp_hit_o && !lkp_near_o)); // R2

  AST_NEAR_IS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_near_o |-> lkp_hit_o); // R4

  AST_INS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && !fl_any) |=> (vic_ptr_o == $past(ptr_nxt))); // R5

  AST_ADV_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vic_adv_i && !flush_all_i) |=> (vic_ptr_o == $past(ptr_nxt))); // R6

  AST_CLEAR_NO_NEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i || fl_any) |=> ##1 !lkp_near_o); // R7

  AST_FLUSH_ALL_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (vic_ptr_o == '0 && !vic_vld_o)); // R8

  AST_INS_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && fl_any && !flush_all_i && !vic_adv_i) |=> $stable(vic_ptr_o)); // R11
endmodule

bind asn_tlb asn_tlb_chk #(.N_ENTRIES(N_ENTRIES), .PPN_W(PPN_W)) u_asn_tlb_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lkp_req_i    (lkp_req_i),
  .lkp_hit_o    (lkp_hit_o),
  .lkp_near_o   (lkp_near_o),
  .lkp_ppn_o    (lkp_ppn_o),
  .ins_i        (ins_i),
  .flush_all_i  (flush_all_i),
  .flush_proc_i (flush_proc_i),
  .flush_addr_i (flush_addr_i),
  .vic_adv_i    (vic_adv_i),
  .vic_ptr_o    (vic_ptr_o),
  .vic_vld_o    (vic_vld_o)
);

// File: tb/asn_tlb_bench.sv
`timescale 1ns/1ps
module asn_tlb_bench;
  localparam int N  = 8;
  localparam int VW = 8;
  localparam int PW = 8;
  localparam int AW = 4;
  localparam int MW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          lkp_req;
  logic [VW-1:0] lkp_vpn;
  logic [AW-1:0] lkp_asn;
  logic          hit, near, glb_o, frd_o, fwr_o;
  logic [PW-1:0] ppn_o;
  logic [AW-1:0] asn_o;
  logic [MW-1:0] rd_o, wr_o;
  logic          ins;
  logic [VW-1:0] ins_vpn;
  logic [PW-1:0] ins_ppn;
  logic [AW-1:0] ins_asn;
  logic          ins_glb, ins_frd, ins_fwr;
  logic [MW-1:0] ins_rd, ins_wr;
  logic          fl_all, fl_proc, fl_addr, adv;
  logic [VW-1:0] fl_vpn;
  logic [AW-1:0] fl_asn;
  logic [IW-1:0] vptr;
  logic          vvld;
  logic [VW-1:0] vvpn;
  logic [PW-1:0] vppn;

  asn_tlb #(.N_ENTRIES(N), .VPN_W(VW), .PPN_W(PW), .ASN_W(AW), .MODE_W(MW)) u_asn_tlb (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_req_i(lkp_req), .lkp_vpn_i(lkp_vpn), .lkp_asn_i(lkp_asn),
    .lkp_hit_o(hit), .lkp_near_o(near), .lkp_ppn_o(ppn_o), .lkp_asn_o(asn_o),
    .lkp_glb_o(glb_o), .lkp_rd_en_o(rd_o), .lkp_wr_en_o(wr_o),
    .lkp_frd_o(frd_o), .lkp_fwr_o(fwr_o),
    .ins_i(ins), .ins_vpn_i(ins_vpn), .ins_ppn_i(ins_ppn), .ins_asn_i(ins_asn),
    .ins_glb_i(ins_glb), .ins_rd_en_i(ins_rd), .ins_wr_en_i(ins_wr),
    .ins_frd_i(ins_frd), .ins_fwr_i(ins_fwr),
    .flush_all_i(fl_all), .flush_proc_i(fl_proc), .flush_addr_i(fl_addr),
    .flush_vpn_i(fl_vpn), .flush_asn_i(fl_asn), .vic_adv_i(adv),
    .vic_ptr_o(vptr), .vic_vld_o(vvld), .vic_vpn_o(vvpn), .vic_ppn_o(vppn)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expectation model state
  bit          m_vld [N];
  logic [VW-1:0] m_tag [N];
  logic [PW-1:0] m_ppn [N];
  logic [AW-1:0] m_asn [N];
  bit          m_glb [N];
  logic [MW-1:0] m_rd [N];
  logic [MW-1:0] m_wr [N];
  bit          m_fr [N];
  bit          m_fw [N];
  int          m_ptr;
  int          c_idx [3];
  bit          c_v [3];

  task automatic chk(string r, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lkp_req = 0; lkp_vpn = '0; lkp_asn = '0;
    ins = 0; ins_vpn = '0; ins_ppn = '0; ins_asn = '0; ins_glb = 0;
    ins_rd = '0; ins_wr = '0; ins_frd = 0; ins_fwr = 0;
    fl_all = 0; fl_proc = 0; fl_addr = 0; fl_vpn = '0; fl_asn = '0; adv = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic bit m_match(int i, logic [VW-1:0] v, logic [AW-1:0] a);
    return m_vld[i] && (m_tag[i] == v) && (m_glb[i] || (m_asn[i] == a));
  endfunction

  function automatic int step_ptr(int p);
    return (p == N - 1) ? 0 : p + 1;
  endfunction

  task automatic m_clear_cache();
    for (int k = 0; k < 3; k++) c_v[k] = 0;
  endtask

  task automatic chk_vic(string r);
    chk(r, vptr, m_ptr);
    chk(r, vvld, m_vld[m_ptr]);
    if (m_vld[m_ptr]) begin
      chk(r, vvpn, m_tag[m_ptr]);
      chk(r, vppn, m_ppn[m_ptr]);
    end
  endtask

  // insert; optional same-cycle step or non-global flush
  task automatic do_ins(string r, logic [VW-1:0] v, logic [PW-1:0] p, logic [AW-1:0] a,
                        bit g, logic [MW-1:0] rd, logic [MW-1:0] wr, bit fr, bit fw,
                        bit with_adv, bit with_fp);
    @(negedge clk);
    ins = 1; ins_vpn = v; ins_ppn = p; ins_asn = a; ins_glb = g;
    ins_rd = rd; ins_wr = wr; ins_frd = fr; ins_fwr = fw;
    adv = with_adv; fl_proc = with_fp;
    tick();
    if (with_fp) begin
      for (int i = 0; i < N; i++) if (!m_glb[i]) m_vld[i] = 0;
    end else begin
      m_vld[m_ptr] = 1; m_tag[m_ptr] = v; m_ppn[m_ptr] = p; m_asn[m_ptr] = a;
      m_glb[m_ptr] = g; m_rd[m_ptr] = rd; m_wr[m_ptr] = wr;
      m_fr[m_ptr] = fr; m_fw[m_ptr] = fw;
      m_ptr = step_ptr(m_ptr);
    end
    if (with_adv && with_fp) m_ptr = step_ptr(m_ptr);
    m_clear_cache();
    idle_inputs();
    chk_vic(r);
  endtask

  task automatic do_lkp(string r, logic [VW-1:0] v, logic [AW-1:0] a);
    bit e_hit = 0, e_near = 0;
    int sel = 0;
    for (int k = 2; k >= 0; k--)
      if (c_v[k] && m_match(c_idx[k], v, a)) begin e_near = 1; sel = c_idx[k]; end
    if (e_near) e_hit = 1;
    else
      for (int i = N - 1; i >= 0; i--)
        if (m_match(i, v, a)) begin e_hit = 1; sel = i; end
    @(negedge clk);
    lkp_req = 1; lkp_vpn = v; lkp_asn = a;
    tick();
    idle_inputs();
    chk(r, hit, e_hit);
    chk(r, near, e_near);
    if (e_hit)
      chk(r, {ppn_o, asn_o, glb_o, rd_o, wr_o, frd_o, fwr_o},
             {m_ppn[sel], m_asn[sel], m_glb[sel], m_rd[sel], m_wr[sel], m_fr[sel], m_fw[sel]});
    else
      chk(r, {ppn_o, asn_o, glb_o, rd_o, wr_o, frd_o, fwr_o}, 0);
    if (e_hit && !e_near) begin
      c_idx[2] = c_idx[1]; c_v[2] = c_v[1];
      c_idx[1] = c_idx[0]; c_v[1] = c_v[0];
      c_idx[0] = sel;      c_v[0] = 1;
    end
  endtask

  task automatic do_flush(string r, bit fa, bit fp, bit fd, logic [VW-1:0] v, logic [AW-1:0] a);
    @(negedge clk);
    fl_all = fa; fl_proc = fp; fl_addr = fd; fl_vpn = v; fl_asn = a;
    tick();
    for (int i = 0; i < N; i++) begin
      if (fa) m_vld[i] = 0;
      if (fp && !m_glb[i]) m_vld[i] = 0;
      if (fd && m_match(i, v, a)) m_vld[i] = 0;
    end
    if (fa) m_ptr = 0;
    m_clear_cache();
    idle_inputs();
    chk_vic(r);
  endtask

  task automatic do_adv(string r);
    @(negedge clk);
    adv = 1;
    tick();
    m_ptr = step_ptr(m_ptr);
    idle_inputs();
    chk_vic(r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_tag[i] = '0; m_ppn[i] = '0; m_asn[i] = '0; m_glb[i] = 0;
      m_rd[i] = '0; m_wr[i] = '0; m_fr[i] = 0; m_fw[i] = 0;
    end
    m_ptr = 0;
    m_clear_cache();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();

    // R12 reset state
    chk("R12 hit", hit, 0);
    chk("R12 ptr", vptr, 0);
    chk("R12 vld", vvld, 0);
    do_lkp("R12 lookup empty", 8'h20, 4'd0);

    // R5 fill every slot, pointer wraps
    for (int i = 0; i < N; i++)
      do_ins("R5 fill", 8'(8'h20 + (i % 6)), 8'(8'hA0 + i * 3), 4'(i % 4),
             (i % 3) == 2, 4'(i), 4'(~i), i[0], i[1], 0, 0);
    chk("R5 wrap", vptr, 0);

    // R1 R3 R4 sweep of pages and identifiers, twice to use recent cache
    for (int pass = 0; pass < 2; pass++)
      for (int v = 0; v < 7; v++)
        for (int a = 0; a < 4; a++)
          do_lkp("R1 R3 R4 sweep", 8'(8'h20 + v), 4'(a));

    // R2 no request gives no hit
    tick();
    chk("R2 idle", hit, 0);

    // R5 overwrite of valid slot 0
    do_ins("R5 overwrite", 8'h77, 8'h5A, 4'd3, 0, 4'h1, 4'h2, 1, 0, 0, 0);
    do_lkp("R5 new tag", 8'h77, 4'd3);
    do_lkp("R5 old tag gone", 8'h20, 4'd0);

    // R8 flush all
    do_flush("R8 flush all", 1, 0, 0, '0, '0);
    chk("R8 ptr", vptr, 0);
    for (int v = 0; v < 7; v++) do_lkp("R8 miss", 8'(8'h20 + v), 4'd2);

    // R3 R4 R7 duplicate tags
    do_ins("R5 dup0", 8'h55, 8'hB0, 4'd1, 0, 4'h3, 4'h3, 0, 0, 0, 0);
    do_ins("R5 dup1", 8'h55, 8'hB1, 4'd5, 1, 4'h7, 4'h1, 1, 1, 0, 0);
    do_ins("R5 dup2", 8'h55, 8'hB2, 4'd2, 0, 4'hF, 4'h0, 0, 1, 0, 0);
    do_lkp("R3 lowest index", 8'h55, 4'd2);
    chk("R3 ppn", ppn_o, 8'hB1);
    do_lkp("R4 near beats lower", 8'h55, 4'd1);
    chk("R4 near ppn", ppn_o, 8'hB1);
    chk("R4 near flag", near, 1);
    do_ins("R5 extra", 8'h66, 8'hC3, 4'd1, 0, 4'h1, 4'h1, 0, 0, 0, 0);
    do_lkp("R7 cache emptied", 8'h55, 4'd1);
    chk("R7 ppn", ppn_o, 8'hB0);
    chk("R7 near", near, 0);

    // R10 page flush: removes global and matching, keeps other identifier
    do_flush("R10 flush page", 0, 0, 1, 8'h55, 4'd2);
    do_lkp("R10 kept", 8'h55, 4'd1);
    chk("R10 kept ppn", ppn_o, 8'hB0);
    do_lkp("R10 removed", 8'h55, 4'd2);
    chk("R10 removed hit", hit, 0);
    do_lkp("R10 other page", 8'h66, 4'd1);

    // R9 non-global flush
    do_ins("R5 glb", 8'h44, 8'hD4, 4'd7, 1, 4'h2, 4'h2, 0, 0, 0, 0);
    do_flush("R9 flush proc", 0, 1, 0, '0, '0);
    do_lkp("R9 global kept", 8'h44, 4'd0);
    chk("R9 global hit", hit, 1);
    do_lkp("R9 nonglobal gone", 8'h66, 4'd1);
    chk("R9 nonglobal hit", hit, 0);
    do_lkp("R9 nonglobal gone2", 8'h55, 4'd1);

    // R6 step without write and with insert
    do_adv("R6 step");
    do_ins("R6 ins with step", 8'h33, 8'hE3, 4'd4, 0, 4'h4, 4'h4, 0, 0, 1, 0);
    do_lkp("R6 inserted", 8'h33, 4'd4);
    for (int s = 0; s < N; s++) do_adv("R6 walk");

    // R11 insert dropped by flush
    do_ins("R11 ins with flush", 8'h99, 8'hF9, 4'd1, 1, 4'h1, 4'h1, 0, 0, 0, 1);
    do_lkp("R11 dropped", 8'h99, 4'd1);
    chk("R11 dropped hit", hit, 0);

    // R13 lookup in same cycle as flush sees old contents
    @(negedge clk);
    lkp_req = 1; lkp_vpn = 8'h44; lkp_asn = 4'd0; fl_all = 1;
    tick();
    idle_inputs();
    chk("R13 old contents", hit, 1);
    chk("R13 old ppn", ppn_o, 8'hD4);
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    m_ptr = 0;
    m_clear_cache();
    do_lkp("R13 after flush", 8'h44, 4'd0);
    chk("R8 final ptr", vptr, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule